// File: doc/BRIEF.md
# E1 Transmit Alarm Bit Inserter

This block sits in an E1 transmit path and rewrites two kinds of alarm-indication bits in the outgoing serial stream. Everything else passes through unchanged. The upstream framer supplies one bit per clock, qualified by a valid strobe. With each bit it also supplies position information: the frame number inside the CAS multiframe, the frame number inside the CRC-4 multiframe, the time slot, and the bit index within the slot.

**Multiframe yellow bit.** The inserter can overwrite this bit in time slot 16 of CAS frame 0. Control is either manual, from a register bit, or automatic, following the receive-side flag that reports loss of CAS multiframe alignment.

**E-bits.** The inserter can also overwrite the two E-bits in time slot 0. These carry far-end block error reports. The reports come either from CRC-4 error pulses that the receiver raises per submultiframe, or directly from two register bits.

Each function has its own master insert enable. Inside that enable, the manual source wins over the automatic one. The output is registered, so it appears exactly one clock after the input bit, together with a delayed valid.

Top module: `e1_alarm_bit_inserter`

## Requirements
- R1: `tx_data_out` and `tx_valid_out` are 0 during reset. After reset, each input bit and its valid appear on the outputs exactly one clock later.
- R2: A bit that is neither the yellow position nor an E-bit position leaves the block unchanged. This covers bits with valid low.
- R3: The yellow position is CAS frame 0, time slot 16, bit index 5 (bit index 0 is the first bit sent, so index 5 is bit 6). When `mfy_insert_en` is 0, this bit passes unchanged. A neighbouring bit (index 4) is never altered.
- R4: With `mfy_insert_en` = 1 and `mfy_force` = 1, the yellow bit is sent as 1 whatever the automatic source says.
- R5: With `mfy_insert_en` = 1 and `mfy_force` = 0, the yellow bit equals `mfy_auto_en` AND `rx_cas_mf_lost`. It is therefore 0 when no alarm applies.
- R6: The E-bits sit at bit index 0 of time slot 0. The first is in CRC-4 frame 13 and reports submultiframe I; the second is in CRC-4 frame 15 and reports submultiframe II. With automatic insertion active (`ebit_insert_en` = 1, `e1_mode` = 1, `ebit_force` = 0) and no error reported, each is sent as 1.
- R7: A pulse on `rx_crc_err_i` or `rx_crc_err_ii` is collected during one CRC-4 multiframe. In the following multiframe, the matching E-bit is sent as 0. In the multiframe after that it returns to 1, unless a new error arrived. A multiframe starts at the valid bit of CRC-4 frame 0, time slot 0, bit index 0. A pulse that arrives in that same cycle belongs to the new multiframe.
- R8: With `ebit_insert_en` = 1, `e1_mode` = 1 and `ebit_force` = 1, the E-bits are sent as `ebit_val_i` and `ebit_val_ii` respectively. Any reported error is ignored.
- R9: When `ebit_insert_en` = 0 or `e1_mode` = 0, the E-bit positions pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid_in | input | 1 | Input bit is valid this cycle |
| tx_data_in | input | 1 | Serial transmit bit |
| cas_frame | input | 4 | Frame number in the CAS multiframe |
| crc_frame | input | 4 | Frame number in the CRC-4 multiframe |
| timeslot | input | 5 | Time slot of the current bit |
| bit_idx | input | 3 | Bit index in the slot, 0 sent first |
| e1_mode | input | 1 | Framer runs in E1 mode |
| mfy_insert_en | input | 1 | Master enable for yellow bit insertion |
| mfy_force | input | 1 | Manual yellow alarm |
| mfy_auto_en | input | 1 | Yellow follows receive CAS alignment loss |
| rx_cas_mf_lost | input | 1 | Receive CAS multiframe alignment lost |
| ebit_insert_en | input | 1 | Master enable for E-bit insertion |
| ebit_force | input | 1 | E-bits taken from register values |
| ebit_val_i | input | 1 | Manual value for the submultiframe I E-bit |
| ebit_val_ii | input | 1 | Manual value for the submultiframe II E-bit |
| rx_crc_err_i | input | 1 | Receive CRC-4 error pulse, submultiframe I |
| rx_crc_err_ii | input | 1 | Receive CRC-4 error pulse, submultiframe II |
| tx_valid_out | output | 1 | Delayed valid |
| tx_data_out | output | 1 | Transmit bit after insertion |

## Verification
Every data and valid result is due one clock after the bit is presented.

**Sampling.** The bench drives each bit on a falling edge and reads the output on the next falling edge. This leaves exactly one rising edge between stimulus and check, and keeps both actions clear of the active edge.

**Error pulses.** An error report is due one whole CRC-4 multiframe later. The bench therefore steps the position inputs explicitly: it presents E-bit positions before and after a multiframe-start bit, and checks each E-bit at its own position. A pulse coinciding with the start bit is checked separately for its one-multiframe deferral.

// File: rtl/e1_alarm_bit_inserter.sv
module e1_alarm_bit_inserter #(
  parameter int Y_SLOT     = 16,
  parameter int Y_BIT      = 5,
  parameter int E_BIT      = 0,
  parameter int E_FRAME_I  = 13,
  parameter int E_FRAME_II = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid_in,
  input  logic       tx_data_in,
  input  logic [3:0] cas_frame,
  input  logic [3:0] crc_frame,
  input  logic [4:0] timeslot,
  input  logic [2:0] bit_idx,
  input  logic       e1_mode,
  input  logic       mfy_insert_en,
  input  logic       mfy_force,
  input  logic       mfy_auto_en,
  input  logic       rx_cas_mf_lost,
  input  logic       ebit_insert_en,
  input  logic       ebit_force,
  input  logic       ebit_val_i,
  input  logic       ebit_val_ii,
  input  logic       rx_crc_err_i,
  input  logic       rx_crc_err_ii,
  output logic       tx_valid_out,
  output logic       tx_data_out
);
  localparam logic [4:0] YS  = 5'(Y_SLOT);
  localparam logic [2:0] YB  = 3'(Y_BIT);
  localparam logic [2:0] EB  = 3'(E_BIT);
  localparam logic [3:0] EF1 = 4'(E_FRAME_I);
  localparam logic [3:0] EF2 = 4'(E_FRAME_II);

  logic       ts0_first, y_pos, e1_pos, e2_pos, mf_start;
  logic       y_on, e_on;
  logic [1:0] err_acc, err_rep;
  logic       next_bit;

  assign ts0_first = tx_valid_in && timeslot == 5'd0 && bit_idx == EB;
  assign y_pos     = tx_valid_in && cas_frame == 4'd0 && timeslot == YS && bit_idx == YB;
  assign e1_pos    = ts0_first && crc_frame == EF1;
  assign e2_pos    = ts0_first && crc_frame == EF2;
  assign mf_start  = ts0_first && crc_frame == 4'd0;

  assign y_on = mfy_insert_en && y_pos;
  assign e_on = ebit_insert_en && e1_mode;

  always_comb begin
    next_bit = tx_data_in;
    if (y_on)
      next_bit = mfy_force | (mfy_auto_en & rx_cas_mf_lost);
    else if (e_on && e1_pos)
      next_bit = ebit_force ? ebit_val_i : ~err_rep[0];
    else if (e_on && e2_pos)
      next_bit = ebit_force ? ebit_val_ii : ~err_rep[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_acc <= 2'b00;
      err_rep <= 2'b00;
    end else if (mf_start) begin
      err_rep <= err_acc;
      err_acc <= {rx_crc_err_ii, rx_crc_err_i};
    end else begin
      err_acc <= err_acc | {rx_crc_err_ii, rx_crc_err_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_out <= 1'b0;
      tx_data_out  <= 1'b0;
    end else begin
      tx_valid_out <= tx_valid_in;
      tx_data_out  <= next_bit;
    end
  end
endmodule

// File: rtl/e1_alarm_bit_inserter_chk.sv
module e1_alarm_bit_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid_in,
  input logic       tx_data_in,
  input logic [3:0] cas_frame,
  input logic [3:0] crc_frame,
  input logic [4:0] timeslot,
  input logic [2:0] bit_idx,
  input logic       e1_mode,
  input logic       mfy_insert_en,
  input logic       mfy_force,
  input logic       mfy_auto_en,
  input logic       rx_cas_mf_lost,
  input logic       ebit_insert_en,
  input logic       ebit_force,
  input logic       ebit_val_i,
  input logic       ebit_val_ii,
  input logic       tx_valid_out,
  input logic       tx_data_out
);
  logic at_y, at_e1, at_e2;
  assign at_y  = tx_valid_in && cas_frame == 4'd0 && timeslot == 5'd16 && bit_idx == 3'd5;
  assign at_e1 = tx_valid_in && timeslot == 5'd0 && bit_idx == 3'd0 && crc_frame == 4'd13;
  assign at_e2 = tx_valid_in && timeslot == 5'd0 && bit_idx == 3'd0 && crc_frame == 4'd15;

  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tx_valid_out == $past(tx_valid_in));

  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_y && !at_e1 && !at_e2) |=> tx_data_out == $past(tx_data_in));

  a_r3_y_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (at_y && !mfy_insert_en) |=> tx_data_out == $past(tx_data_in));

  a_r4_y_manual: assert property (@(posedge clk) disable iff (!rst_n)
    (at_y && mfy_insert_en && mfy_force) |=> tx_data_out);

  a_r5_y_auto: assert property (@(posedge clk) disable iff (!rst_n)
    (at_y && mfy_insert_en && !mfy_force) |=> tx_data_out == $past(mfy_auto_en && rx_cas_mf_lost));

  a_r8_e_manual_i: assert property (@(posedge clk) disable iff (!rst_n)
    (at_e1 && ebit_insert_en && e1_mode && ebit_force) |=> tx_data_out == $past(ebit_val_i));

  a_r8_e_manual_ii: assert property (@(posedge clk) disable iff (!rst_n)
    (at_e2 && ebit_insert_en && e1_mode && ebit_force) |=> tx_data_out == $past(ebit_val_ii));

  a_r9_e_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((at_e1 || at_e2) && (!ebit_insert_en || !e1_mode)) |=> tx_data_out == $past(tx_data_in));
endmodule

bind e1_alarm_bit_inserter e1_alarm_bit_inserter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_valid_in(tx_valid_in), .tx_data_in(tx_data_in),
  .cas_frame(cas_frame), .crc_frame(crc_frame), .timeslot(timeslot), .bit_idx(bit_idx),
  .e1_mode(e1_mode), .mfy_insert_en(mfy_insert_en), .mfy_force(mfy_force),
  .mfy_auto_en(mfy_auto_en), .rx_cas_mf_lost(rx_cas_mf_lost),
  .ebit_insert_en(ebit_insert_en), .ebit_force(ebit_force),
  .ebit_val_i(ebit_val_i), .ebit_val_ii(ebit_val_ii),
  .tx_valid_out(tx_valid_out), .tx_data_out(tx_data_out)
);

// File: tb/e1_alarm_bit_inserter_tb_top.sv
`timescale 1ns/1ps
module e1_alarm_bit_inserter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid_in = 1'b0, tx_data_in = 1'b0;
  logic [3:0] cas_frame = '0, crc_frame = '0;
  logic [4:0] timeslot = '0;
  logic [2:0] bit_idx = '0;
  logic e1_mode = 1'b1, mfy_insert_en = 1'b0, mfy_force = 1'b0, mfy_auto_en = 1'b0;
  logic rx_cas_mf_lost = 1'b0, ebit_insert_en = 1'b0, ebit_force = 1'b0;
  logic ebit_val_i = 1'b0, ebit_val_ii = 1'b0, rx_crc_err_i = 1'b0, rx_crc_err_ii = 1'b0;
  logic tx_valid_out, tx_data_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  e1_alarm_bit_inserter dut_i (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [3:0] cf, input logic [3:0] rf, input logic [4:0] ts,
                      input logic [2:0] bi, input logic d, output logic q);
    tx_valid_in = 1'b1; cas_frame = cf; crc_frame = rf; timeslot = ts; bit_idx = bi; tx_data_in = d;
    @(negedge clk);
    q = tx_data_out;
    rx_crc_err_i = 1'b0; rx_crc_err_ii = 1'b0;
  endtask

  task automatic mf_start();
    logic q;
    xfer(4'd1, 4'd0, 5'd0, 3'd0, 1'b1, q);
  endtask

  task automatic t_reset();
    chk("R1 reset data", tx_data_out, 1'b0);
    chk("R1 reset valid", tx_valid_out, 1'b0);
  endtask

  task automatic t_passthrough();
    logic q;
    mfy_insert_en = 1; mfy_force = 1; ebit_insert_en = 1;
    xfer(4'd0, 4'd13, 5'd5, 3'd0, 1'b0, q); chk("R2 slot5 zero", q, 1'b0);
    chk("R1 valid delayed", tx_valid_out, 1'b1);
    xfer(4'd0, 4'd2, 5'd16, 3'd4, 1'b0, q); chk("R3 neighbour bit", q, 1'b0);
    xfer(4'd3, 4'd7, 5'd16, 3'd5, 1'b1, q); chk("R2 ts16 other frame", q, 1'b1);
    xfer(4'd0, 4'd13, 5'd0, 3'd1, 1'b0, q); chk("R2 ts0 bit2", q, 1'b0);
    tx_valid_in = 0; tx_data_in = 1; cas_frame = 0; timeslot = 16; bit_idx = 5; mfy_force = 1;
    @(negedge clk);
    chk("R1 valid low out", tx_valid_out, 1'b0);
    chk("R2 invalid passes", tx_data_out, 1'b1);
    mfy_insert_en = 0; mfy_force = 0; ebit_insert_en = 0;
  endtask

  task automatic t_y_bit();
    logic q;
    mfy_insert_en = 0; mfy_force = 1;
    xfer(4'd0, 4'd0, 5'd16, 3'd5, 1'b0, q); chk("R3 disabled zero", q, 1'b0);
    mfy_force = 0; mfy_auto_en = 1; rx_cas_mf_lost = 1;
    xfer(4'd0, 4'd1, 5'd16, 3'd5, 1'b0, q); chk("R3 disabled auto", q, 1'b0);
    mfy_insert_en = 1; mfy_force = 1; mfy_auto_en = 0; rx_cas_mf_lost = 0;
    xfer(4'd0, 4'd1, 5'd16, 3'd5, 1'b0, q); chk("R4 manual", q, 1'b1);
    mfy_auto_en = 1;
    xfer(4'd0, 4'd1, 5'd16, 3'd5, 1'b0, q); chk("R4 manual over auto", q, 1'b1);
    mfy_force = 0; rx_cas_mf_lost = 1;
    xfer(4'd0, 4'd1, 5'd16, 3'd5, 1'b0, q); chk("R5 auto loss", q, 1'b1);
    rx_cas_mf_lost = 0;
    xfer(4'd0, 4'd1, 5'd16, 3'd5, 1'b1, q); chk("R5 auto aligned", q, 1'b0);
    mfy_auto_en = 0; rx_cas_mf_lost = 1;
    xfer(4'd0, 4'd1, 5'd16, 3'd5, 1'b1, q); chk("R5 no source", q, 1'b0);
    mfy_insert_en = 0; rx_cas_mf_lost = 0;
  endtask

  task automatic t_ebit_auto();
    logic q;
    ebit_insert_en = 1; e1_mode = 1; ebit_force = 0;
    mf_start(); mf_start();
    xfer(4'd1, 4'd13, 5'd0, 3'd0, 1'b0, q); chk("R6 E1 no error", q, 1'b1);
    xfer(4'd1, 4'd15, 5'd0, 3'd0, 1'b0, q); chk("R6 E2 no error", q, 1'b1);
    rx_crc_err_i = 1;
    xfer(4'd1, 4'd3, 5'd4, 3'd2, 1'b0, q);
    xfer(4'd1, 4'd13, 5'd0, 3'd0, 1'b1, q); chk("R7 not same mf", q, 1'b1);
    mf_start();
    xfer(4'd1, 4'd13, 5'd0, 3'd0, 1'b1, q); chk("R7 E1 reported", q, 1'b0);
    xfer(4'd1, 4'd15, 5'd0, 3'd0, 1'b0, q); chk("R7 E2 clean", q, 1'b1);
    mf_start();
    xfer(4'd1, 4'd13, 5'd0, 3'd0, 1'b0, q); chk("R7 E1 cleared", q, 1'b1);
    rx_crc_err_ii = 1;
    mf_start();
    xfer(4'd1, 4'd15, 5'd0, 3'd0, 1'b1, q); chk("R7 start pulse deferred", q, 1'b1);
    mf_start();
    xfer(4'd1, 4'd15, 5'd0, 3'd0, 1'b1, q); chk("R7 start pulse reported", q, 1'b0);
    mf_start();
  endtask

  task automatic t_ebit_manual();
    logic q;
    ebit_insert_en = 1; e1_mode = 1; ebit_force = 0;
    rx_crc_err_i = 1; rx_crc_err_ii = 1;
    xfer(4'd1, 4'd4, 5'd9, 3'd3, 1'b0, q);
    mf_start();
    ebit_force = 1; ebit_val_i = 1; ebit_val_ii = 0;
    xfer(4'd1, 4'd13, 5'd0, 3'd0, 1'b0, q); chk("R8 manual E1 over error", q, 1'b1);
    xfer(4'd1, 4'd15, 5'd0, 3'd0, 1'b1, q); chk("R8 manual E2", q, 1'b0);
    ebit_val_i = 0; ebit_val_ii = 1;
    xfer(4'd1, 4'd13, 5'd0, 3'd0, 1'b1, q); chk("R8 manual E1 zero", q, 1'b0);
    xfer(4'd1, 4'd15, 5'd0, 3'd0, 1'b0, q); chk("R8 manual E2 one", q, 1'b1);
    ebit_force = 0;
    xfer(4'd1, 4'd15, 5'd0, 3'd0, 1'b1, q); chk("R7 error still reported", q, 1'b0);
  endtask

  task automatic t_ebit_gate();
    logic q;
    ebit_insert_en = 0; e1_mode = 1; ebit_force = 1; ebit_val_i = 1;
    xfer(4'd1, 4'd13, 5'd0, 3'd0, 1'b0, q); chk("R9 insert off", q, 1'b0);
    ebit_insert_en = 1; e1_mode = 0; ebit_force = 0;
    xfer(4'd1, 4'd15, 5'd0, 3'd0, 1'b0, q); chk("R9 not E1", q, 1'b0);
    xfer(4'd1, 4'd13, 5'd0, 3'd0, 1'b1, q); chk("R9 not E1 one", q, 1'b1);
    ebit_insert_en = 0; e1_mode = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_passthrough();
    t_y_bit();
    t_ebit_auto();
    t_ebit_manual();
    t_ebit_gate();
    tx_valid_in = 0;
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule